// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

The block is an 8-bit up/down timer that produces two symmetric PWM waveforms. An up/down counter climbs from zero to a TOP value, stays at TOP for one tick, then falls back to zero and repeats. TOP is either the full-scale value or the active compare value of channel A. Each of the two compare channels, A and B, compares its active compare value with the count. The channel sets or clears its waveform bit according to whether the counter is climbing or falling. An external prescaler supplies a one-cycle advance pulse, and the counter moves only on cycles where that pulse is high.

The counter is a two-state machine. `ST_UP` moves to `ST_DOWN` on an advance pulse while the count is at or above TOP; this transition is called the top turn. `ST_DOWN` moves to `ST_UP` on an advance pulse while the count is zero; this transition is called the bottom turn. New compare values wait in the compare inputs and become active only at the top turn, so a half-written period never reaches the outputs. At the bottom turn every PWM-mode output is put back to the level that belongs below the compare point. This is done even when no match happened there, so the waveform stays symmetric about zero. A sticky flag records each arrival at zero, and a write-one strobe clears it.

Top module: `pcpwm_timer`

## Requirements
- R1: While reset is held, and after it is released, `count_o` is 0, both waveform bits are 0, `ovf_o` is 0 and both match strobes are 0. The counter starts in the up state, and both active compare values are 0.
- R2: The count changes only on a clock edge where `tick_i` is high. Each step changes it by exactly one. It rises from 0 to TOP, shows TOP for one tick, then falls to 0, shows 0 for one tick, and rises again. With ticks on every cycle and TOP = T > 0, one period reads 0,1,…,T,…,1 (2T cycles).
- R3: With `top_sel_i` = 0, TOP is 255. With `top_sel_i` = 1, TOP is channel A's active compare value.
- R4: The values on `cmp_a_i` and `cmp_b_i` are copied into the active compare values only at the top turn. A change made earlier in the period does not alter that period's peak.
- R5: `ovf_o` rises in the cycle after a tick that moves the count from a nonzero value to 0. It stays high until a cycle with `ovf_clr_i` = 1. When both the setting event and the clear fall on the same edge, the flag is set.
- R6: `match_a_o` / `match_b_o` is high for the one cycle after each tick on which the count equals that channel's active compare value. This holds in every output mode.
- R7: Output mode code 2'b10 is non-inverting: a match while climbing drives the bit to 0, and a match while falling drives it to 1. Code 2'b11 drives the opposite levels. The bit changes one cycle after the matching tick.
- R8: Code 2'b01 on channel A, with `top_sel_i` = 1, inverts wave A on every channel-A match. Code 2'b01 on channel B, or on A with `top_sel_i` = 0, leaves the bit unchanged.
- R9: Code 2'b00 leaves the channel's waveform bit unchanged.
- R10: In codes 2'b10/2'b11, on every tick an active compare value of 0 forces the non-inverted level to 0, and a value of 255 forces it to 1. This rule takes priority over matches. Code 2'b11 gives the complement.
- R11: In codes 2'b10/2'b11, at the bottom turn with an active compare value strictly between 0 and 255, the non-inverted level is driven to 1 (code 2'b11: to 0). This happens even when the count never matched that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance pulse from the prescaler |
| top_sel_i | input | 1 | 0: TOP is 255; 1: TOP is channel A's active compare value |
| cmp_a_i | input | 8 | Compare value for channel A (becomes active at the top turn) |
| cmp_b_i | input | 8 | Compare value for channel B (becomes active at the top turn) |
| mode_a_i | input | 2 | Output mode of channel A (00 hold, 01 toggle, 10 non-inverting, 11 inverting) |
| mode_b_i | input | 2 | Output mode of channel B (01 behaves as hold) |
| ovf_clr_i | input | 1 | Write-one strobe that clears the bottom flag |
| count_o | output | 8 | Current count |
| wave_a_o | output | 1 | Waveform bit of channel A |
| wave_b_o | output | 1 | Waveform bit of channel B |
| match_a_o | output | 1 | One-cycle pulse after a channel-A compare match |
| match_b_o | output | 1 | One-cycle pulse after a channel-B compare match |
| ovf_o | output | 1 | Sticky flag, set on arrival at zero |

## Verification
A wrong slope state shows on `count_o` at the very next tick, as a step in the wrong direction or a missing hold at TOP or zero. A stale or early active compare value appears within one period, as a wrong peak when TOP comes from channel A, or as match strobes at the wrong count. A corrupted waveform bit persists until the next match or the next bottom turn, so it is visible for up to one full period. A reference model in the bench steps alongside the design and compares every output on every clock. This catches each of these faults in the cycle it first appears.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    // Slope of the up/down counter
    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } slope_e;

    // Per-channel output behaviour
    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_NONINV = 2'b10,
        OM_INV    = 2'b11
    } outmode_e;

endpackage

// File: rtl/pcpwm_counter.sv
module pcpwm_counter
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output slope_e       slope,
    output logic         turn_top,
    output logic         turn_bottom,
    output logic         reach_zero
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    slope_e       slope_n;
    logic [W-1:0] cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slope <= ST_UP;
            cnt   <= ZERO;
        end else begin
            slope <= slope_n;
            cnt   <= cnt_n;
        end
    end

    // Next state and turn outputs
    always_comb begin
        slope_n     = slope;
        cnt_n       = cnt;
        turn_top    = 1'b0;
        turn_bottom = 1'b0;
        if (tick) begin
            unique case (slope)
                ST_UP: begin
                    if (cnt >= top) begin
                        turn_top = 1'b1;
                        slope_n  = ST_DOWN;
                        cnt_n    = (cnt == ZERO) ? ZERO : cnt - ONE;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                ST_DOWN: begin
                    if (cnt == ZERO) begin
                        turn_bottom = 1'b1;
                        slope_n     = ST_UP;
                        cnt_n       = (top == ZERO) ? ZERO : ONE;
                    end else begin
                        cnt_n = cnt - ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign reach_zero = tick && (cnt != ZERO) && (cnt_n == ZERO);

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
    import pcpwm_pkg::*;
#(
    parameter int W          = 8,
    parameter bit CAN_TOGGLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  slope_e       slope,
    input  logic         load,
    input  logic         bottom,
    input  logic [W-1:0] cmp_in,
    input  logic [1:0]   mode,
    input  logic         toggle_en,
    output logic [W-1:0] cmp_act,
    output logic         wave,
    output logic         match
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] MAX  = '1;

    outmode_e om;
    logic     hit;
    logic     inv;
    logic     lvl;
    logic     wave_n;

    assign om  = outmode_e'(mode);
    assign hit = tick && (cnt == cmp_act);
    assign inv = (om == OM_INV);

    // Next waveform level
    always_comb begin
        wave_n = wave;
        lvl    = wave ^ inv;
        unique case (om)
            OM_OFF: ;
            OM_TOGGLE: begin
                if (CAN_TOGGLE && toggle_en && hit) begin
                    wave_n = ~wave;
                end
            end
            OM_NONINV, OM_INV: begin
                if (tick) begin
                    if (cmp_act == ZERO) begin
                        lvl = 1'b0;
                    end else if (cmp_act == MAX) begin
                        lvl = 1'b1;
                    end else if (hit) begin
                        lvl = (slope == ST_DOWN);
                    end else if (bottom) begin
                        lvl = 1'b1;
                    end
                    wave_n = lvl ^ inv;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_act <= ZERO;
            wave    <= 1'b0;
            match   <= 1'b0;
        end else begin
            if (load) begin
                cmp_act <= cmp_in;
            end
            wave  <= wave_n;
            match <= hit;
        end
    end

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         top_sel_i,
    input  logic [W-1:0] cmp_a_i,
    input  logic [W-1:0] cmp_b_i,
    input  logic [1:0]   mode_a_i,
    input  logic [1:0]   mode_b_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] count_o,
    output logic         wave_a_o,
    output logic         wave_b_o,
    output logic         match_a_o,
    output logic         match_b_o,
    output logic         ovf_o
);

    localparam int           NCH       = 2;
    localparam logic [W-1:0] FIXED_TOP = '1;

    logic [W-1:0] cmp_in [NCH];
    logic [W-1:0] act    [NCH];
    logic [1:0]   mode   [NCH];
    logic         wave   [NCH];
    logic         match  [NCH];

    logic [W-1:0] top;
    logic [W-1:0] cnt;
    slope_e       slope;
    logic         turn_top;
    logic         turn_bottom;
    logic         reach_zero;

    assign cmp_in[0] = cmp_a_i;
    assign cmp_in[1] = cmp_b_i;
    assign mode[0]   = mode_a_i;
    assign mode[1]   = mode_b_i;

    assign top = top_sel_i ? act[0] : FIXED_TOP;

    pcpwm_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_i),
        .top        (top),
        .cnt        (cnt),
        .slope      (slope),
        .turn_top   (turn_top),
        .turn_bottom(turn_bottom),
        .reach_zero (reach_zero)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pcpwm_channel #(
            .W         (W),
            .CAN_TOGGLE(g == 0)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_i),
            .cnt      (cnt),
            .slope    (slope),
            .load     (turn_top),
            .bottom   (turn_bottom),
            .cmp_in   (cmp_in[g]),
            .mode     (mode[g]),
            .toggle_en(top_sel_i),
            .cmp_act  (act[g]),
            .wave     (wave[g]),
            .match    (match[g])
        );
    end

    // Sticky bottom flag: setting wins over clearing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
        end else if (reach_zero) begin
            ovf_o <= 1'b1;
        end else if (ovf_clr_i) begin
            ovf_o <= 1'b0;
        end
    end

    assign count_o   = cnt;
    assign wave_a_o  = wave[0];
    assign wave_b_o  = wave[1];
    assign match_a_o = match[0];
    assign match_b_o = match[1];

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_i,
    input logic [1:0]   mode_b_i,
    input logic         ovf_clr_i,
    input logic [W-1:0] count_o,
    input logic         wave_b_o,
    input logic         match_a_o,
    input logic         match_b_o,
    input logic         ovf_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R2: no advance pulse, no change of count
    a_r2_idle_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_o));

    // R2: every advance moves the count by at most one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (count_o == $past(count_o) + ONE) ||
                   (count_o == $past(count_o) - ONE) ||
                   (count_o == $past(count_o)));

    // R5: flag stays set without a clear
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    // R5: flag rises only while the count shows zero
    a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (count_o == '0));

    // R6: match strobes follow an advance pulse
    a_r6_match_a_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        match_a_o |-> $past(tick_i));

    a_r6_match_b_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        match_b_o |-> $past(tick_i));

    // R9: hold code freezes wave B
    a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b_i == 2'b00) |=> $stable(wave_b_o));

    // R8: toggle code has no effect on channel B
    a_r8_b_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b_i == 2'b01) |=> $stable(wave_b_o));

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(W)) u_chk (.*);

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       top_sel_i = 1'b1;
    logic [7:0] cmp_a_i = 8'd4;
    logic [7:0] cmp_b_i = 8'd2;
    logic [1:0] mode_a_i = 2'b10;
    logic [1:0] mode_b_i = 2'b10;
    logic       ovf_clr_i = 1'b0;
    logic [7:0] count_o;
    logic       wave_a_o, wave_b_o, match_a_o, match_b_o, ovf_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcpwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .top_sel_i(top_sel_i),
        .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .mode_a_i(mode_a_i),
        .mode_b_i(mode_b_i), .ovf_clr_i(ovf_clr_i), .count_o(count_o),
        .wave_a_o(wave_a_o), .wave_b_o(wave_b_o), .match_a_o(match_a_o),
        .match_b_o(match_b_o), .ovf_o(ovf_o)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_cnt = 0, m_acta = 0, m_actb = 0;
    bit m_down = 0, m_wa = 0, m_wb = 0, m_ma = 0, m_mb = 0, m_ovf = 0;

    function automatic bit chan_next(bit cur, logic [1:0] md, int c, bit can_tog,
                                     bit tog_en, bit tk, int cnt, bit down);
        bit hit, bot, lvl;
        hit = tk && (cnt == c);
        bot = tk && down && (cnt == 0);
        if (md == 2'b01) return (can_tog && tog_en && hit) ? !cur : cur;
        if (md == 2'b00 || !tk) return cur;
        if (c == 0) lvl = 1'b0;
        else if (c == 255) lvl = 1'b1;
        else if (hit) lvl = down;
        else if (bot) lvl = 1'b1;
        else return cur;
        return lvl ^ (md == 2'b11);
    endfunction

    always @(posedge clk) begin : ref_model
        int top, nc;
        bit nd;
        if (!rst_n) begin
            m_cnt = 0; m_down = 0; m_acta = 0; m_actb = 0;
            m_wa = 0; m_wb = 0; m_ma = 0; m_mb = 0; m_ovf = 0;
        end else begin
            top = top_sel_i ? m_acta : 255;
            nc = m_cnt;
            nd = m_down;
            if (tick_i) begin
                if (!m_down) begin
                    if (m_cnt >= top) begin nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin nd = 0; nc = (top == 0) ? 0 : 1; end
                    else nc = m_cnt - 1;
                end
            end
            m_wa  = chan_next(m_wa, mode_a_i, m_acta, 1'b1, top_sel_i, tick_i, m_cnt, m_down);
            m_wb  = chan_next(m_wb, mode_b_i, m_actb, 1'b0, top_sel_i, tick_i, m_cnt, m_down);
            m_ma  = tick_i && (m_cnt == m_acta);
            m_mb  = tick_i && (m_cnt == m_actb);
            m_ovf = (tick_i && m_cnt != 0 && nc == 0) || (m_ovf && !ovf_clr_i);
            if (tick_i && !m_down && m_cnt >= top) begin
                m_acta = cmp_a_i;
                m_actb = cmp_b_i;
            end
            m_cnt  = nc;
            m_down = nd;
        end
    end

    // Per-clock comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(count_o == m_cnt[7:0], "R2 count vs model", count_o, m_cnt);
            check(ovf_o == m_ovf, "R5 flag vs model", ovf_o, m_ovf);
            check(match_a_o == m_ma, "R6 match A vs model", match_a_o, m_ma);
            check(match_b_o == m_mb, "R6 match B vs model", match_b_o, m_mb);
            check(wave_a_o == m_wa, "R7/R8/R10/R11 wave A vs model", wave_a_o, m_wa);
            check(wave_b_o == m_wb, "R7/R9/R10/R11 wave B vs model", wave_b_o, m_wb);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wait_val(input int v);
        int n = 0;
        while (count_o != v[7:0] && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic period_peak(output int pk);
        wait_val(0);
        @(negedge clk);
        pk = 0;
        while (count_o != 8'd0) begin
            if (count_o > pk) pk = count_o;
            @(negedge clk);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int pk, hits, flips;
        bit prev;

        cycles(3);
        // R1: reset state
        check(count_o == 0, "R1 count in reset", count_o, 0);
        check({wave_a_o, wave_b_o} == 2'b00, "R1 waves in reset", {wave_a_o, wave_b_o}, 0);
        check({ovf_o, match_a_o, match_b_o} == 3'b000, "R1 flags in reset",
              {ovf_o, match_a_o, match_b_o}, 0);
        rst_n = 1'b1;
        cycles(5);
        check(count_o == 0, "R2 no advance without tick", count_o, 0);

        tick_i = 1'b1;
        cycles(12);
        // R2/R3: triangle with register-defined TOP 4
        wait_val(0);
        for (int k = 0; k < 9; k++) begin
            check(count_o == ((k <= 4) ? k : 8 - k), "R2 triangle sequence",
                  count_o, (k <= 4) ? k : 8 - k);
            @(negedge clk);
        end

        // R7 non-inverting, compare 2
        wait_val(4);
        check(wave_b_o == 1'b0, "R7 non-inverted low at peak", wave_b_o, 0);
        wait_val(0);
        check(wave_b_o == 1'b1, "R7 non-inverted high at zero", wave_b_o, 1);
        // R6: two matches per period
        hits = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); hits += match_b_o; end
        check(hits == 2, "R6 match strobes per period", hits, 2);

        mode_b_i = 2'b11;
        cycles(10);
        wait_val(4);
        check(wave_b_o == 1'b1, "R7 inverted high at peak", wave_b_o, 1);
        wait_val(0);
        check(wave_b_o == 1'b0, "R7 inverted low at zero", wave_b_o, 0);
        mode_b_i = 2'b10;

        // R4: compare change mid-period takes effect after the top turn
        wait_val(1);
        cmp_a_i = 8'd6;
        @(negedge clk);
        pk = 0;
        while (count_o != 8'd0) begin
            if (count_o > pk) pk = count_o;
            @(negedge clk);
        end
        check(pk == 4, "R4 peak before reload", pk, 4);
        period_peak(pk);
        check(pk == 6, "R3/R4 peak after reload", pk, 6);
        cmp_a_i = 8'd4;
        cycles(30);

        // R3: fixed TOP
        top_sel_i = 1'b0;
        period_peak(pk);
        period_peak(pk);
        check(pk == 255, "R3 fixed TOP peak", pk, 255);
        top_sel_i = 1'b1;
        cycles(600);

        // R5: set wins while clear is held
        ovf_clr_i = 1'b1;
        hits = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); hits += ovf_o; end
        check(hits == 1, "R5 set wins over held clear", hits, 1);
        ovf_clr_i = 1'b0;
        cycles(10);
        check(ovf_o == 1'b1, "R5 flag sticky", ovf_o, 1);
        wait_val(3);
        ovf_clr_i = 1'b1;
        @(negedge clk);
        ovf_clr_i = 1'b0;
        check(ovf_o == 1'b0, "R5 flag cleared", ovf_o, 0);

        // R10: extremes
        cmp_b_i = 8'd0;
        cycles(20);
        hits = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); hits += wave_b_o; end
        check(hits == 0, "R10 compare 0 constantly low", hits, 0);
        cmp_b_i = 8'd255;
        mode_b_i = 2'b11;
        cycles(20);
        hits = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); hits += wave_b_o; end
        check(hits == 0, "R10 compare 255 inverted constantly low", hits, 0);
        mode_b_i = 2'b10;
        cycles(10);
        check(wave_b_o == 1'b1, "R10 compare 255 high", wave_b_o, 1);

        // R11: correction without a match (compare above TOP)
        cmp_b_i = 8'd0;
        cycles(20);
        cmp_b_i = 8'd9;
        wait_val(4);
        hits = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); hits += match_b_o; end
        wait_val(2);
        check(hits == 0, "R11 no match occurred", hits, 0);
        check(wave_b_o == 1'b1, "R11 bottom correction level", wave_b_o, 1);

        // R8: toggle on A, no effect on B
        mode_a_i = 2'b01;
        mode_b_i = 2'b01;
        cycles(2);
        flips = 0;
        prev = wave_a_o;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (wave_a_o != prev) flips++;
            prev = wave_a_o;
        end
        check(flips == 2, "R8 A toggles once per period", flips, 2);
        check(wave_b_o == 1'b1, "R8 B unchanged by toggle code", wave_b_o, 1);

        // R9: hold code
        mode_b_i = 2'b00;
        cmp_b_i = 8'd0;
        cycles(24);
        check(wave_b_o == 1'b1, "R9 hold ignores compare 0", wave_b_o, 1);
        mode_a_i = 2'b10;
        mode_b_i = 2'b10;
        cmp_b_i = 8'd3;

        // R2: irregular advance pulses (model comparison runs throughout)
        for (int i = 0; i < 300; i++) begin
            tick_i = (i % 3 != 0);
            @(negedge clk);
        end
        tick_i = 1'b1;
        cycles(20);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule